// File: doc/BRIEF.md
# Configurable Four-Input Lookup Cell

This block is one logic cell of a programmable fabric tile. A 16-entry truth table, held in static configuration bits, lets it implement any Boolean function of four inputs. Four routed inputs form a 4-bit index into that table. The least significant index bit can instead come from a carry-in signal, so that cells can be chained into arithmetic.

The looked-up value leaves the cell in one of two ways. It can pass straight through combinationally, or it can be captured by a clock-enabled flip-flop with a synchronous reset. A configuration bit chooses which of the two drives the main output. The flip-flop contents are also always present on a second output.

The 18-bit configuration word has a fixed layout because neighbouring cells in a tile are packed at 18-bit strides. The layout is:
- bits [15:0]: the truth table.
- bit 16: the output source select.
- bit 17: the I0 source select.

Top module: `logic_cell4`

## Requirements
- R1: With `cfg_word[16]`=0, `cell_out` combinationally equals `cfg_word[idx]`. The index is idx = {lut_in[3], lut_in[2], lut_in[1], i0}, with i0 as the least significant bit.
- R2: With `cfg_word[17]`=0, i0 is `lut_in[0]`, and `carry_in` has no effect on either output.
- R3: With `cfg_word[17]`=1, i0 is `carry_in`, and `lut_in[0]` has no effect on either output.
- R4: On a rising clock edge with `rst`=0 and `ce`=1, the flip-flop loads the looked-up table value. With `ce`=0 it keeps its value.
- R5: On a rising clock edge with `rst`=1, the flip-flop clears to 0, whatever the value of `ce`.
- R6: With `cfg_word[16]`=1, `cell_out` shows the flip-flop contents rather than the combinational lookup.
- R7: `reg_out` always shows the flip-flop contents, whatever `cfg_word[16]` is set to.
- R8: A table value of 16'h8000 gives a four-input AND: the result is 1 only for index 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for the flip-flop |
| rst | input | 1 | Synchronous active-high reset of the flip-flop |
| ce | input | 1 | Clock enable for the flip-flop |
| lut_in | input | 4 | Routed logic inputs; bit 0 is I0 |
| carry_in | input | 1 | Carry-in, used as I0 when `cfg_word[17]`=1 |
| cfg_word | input | 18 | Static configuration: table [15:0], output select [16], I0 select [17] |
| cell_out | output | 1 | Selected output: combinational or registered |
| reg_out | output | 1 | Flip-flop contents |

## Verification
A wrong truth-table bit or a swapped index bit shows up on `cell_out` in combinational mode with no delay. This is why every one of the 65536 tables is swept against two input patterns per table. A flip-flop that misses an enable, ignores reset or loads the wrong lookup shows up on `reg_out` one edge later. In registered mode it also shows up on `cell_out` at that same edge. The bench samples one half-cycle after each edge, and drives each I0 source while the other one toggles.

// File: rtl/logic_cell4_pkg.sv
package logic_cell4_pkg;

    localparam int IN_W  = 4;
    localparam int TT_W  = 1 << IN_W;
    localparam int CFG_W = TT_W + 2;

    // Field order matches the fixed 18-bit layout: [17] I0 source, [16] output source, [15:0] table
    typedef struct packed {
        logic            i0_from_carry;
        logic            out_registered;
        logic [TT_W-1:0] table_bits;
    } cell_cfg_t;

    // Builds the table index, replacing bit 0 with the carry when asked
    function automatic logic [IN_W-1:0] form_index(input logic [IN_W-1:0] raw,
                                                   input logic            carry,
                                                   input logic            use_carry);
        return {raw[IN_W-1:1], (use_carry ? carry : raw[0])};
    endfunction

endpackage

// File: rtl/lc4_index_sel.sv
module lc4_index_sel
    import logic_cell4_pkg::*;
(
    input  logic [IN_W-1:0] raw_in,
    input  logic            carry,
    input  logic            use_carry,
    output logic [IN_W-1:0] index
);

    always_comb begin
        index = form_index(raw_in, carry, use_carry);
    end

endmodule

// File: rtl/lc4_table_mux.sv
module lc4_table_mux #(
    parameter int SEL_W = 4
) (
    input  logic [(1<<SEL_W)-1:0] table_bits,
    input  logic [SEL_W-1:0]      sel,
    output logic                  y
);

    localparam int LEAVES = 1 << SEL_W;
    localparam int NODES  = 2 * LEAVES - 1;

    // Heap-ordered binary tree: node n has children 2n+1 and 2n+2
    logic [NODES-1:0] node;

    genvar g;
    generate
        for (g = 0; g < LEAVES; g++) begin : g_leaf
            assign node[LEAVES-1+g] = table_bits[g];
        end
        for (g = 0; g < LEAVES - 1; g++) begin : g_inner
            localparam int LEVEL = $clog2(g + 2) - 1;
            assign node[g] = sel[SEL_W-1-LEVEL] ? node[2*g+2] : node[2*g+1];
        end
    endgenerate

    assign y = node[0];

endmodule

// File: rtl/lc4_out_reg.sv
module lc4_out_reg (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic d,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (ce)
            q <= d;
    end

    // R5: reset clears the stored bit
    a_r5_reset_clears: assert property (@(posedge clk) rst |=> (q == 1'b0));

    // R4: enabled edge captures the lookup value
    a_r4_capture: assert property (@(posedge clk) disable iff (rst)
        ce |=> (q == $past(d)));

    // R4: disabled edge keeps the stored bit
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(q));

endmodule

// File: rtl/logic_cell4.sv
module logic_cell4
    import logic_cell4_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [IN_W-1:0]  lut_in,
    input  logic             carry_in,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             cell_out,
    output logic             reg_out
);

    cell_cfg_t       cfg;
    logic [IN_W-1:0] index;
    logic            lookup;
    logic            stored;

    assign cfg = cell_cfg_t'(cfg_word);

    lc4_index_sel u_index (
        .raw_in    (lut_in),
        .carry     (carry_in),
        .use_carry (cfg.i0_from_carry),
        .index     (index)
    );

    lc4_table_mux #(.SEL_W(IN_W)) u_table (
        .table_bits (cfg.table_bits),
        .sel        (index),
        .y          (lookup)
    );

    lc4_out_reg u_ff (
        .clk (clk),
        .rst (rst),
        .ce  (ce),
        .d   (lookup),
        .q   (stored)
    );

    always_comb begin
        cell_out = cfg.out_registered ? stored : lookup;
        reg_out  = stored;
    end

    // R6: in registered mode the main output trails the lookup by one enabled edge
    a_r6_registered_path: assert property (@(posedge clk) disable iff (rst)
        (cfg.out_registered && ce && $stable(cfg_word)) |=> (cell_out == $past(lookup)));

endmodule

// File: tb/logic_cell4_tb_top.sv
module logic_cell4_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        ce;
    logic [3:0]  lut_in;
    logic        carry_in;
    logic [17:0] cfg_word;
    logic        cell_out;
    logic        reg_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;   // 250 MHz

    logic_cell4 dut_i (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce),
        .lut_in   (lut_in),
        .carry_in (carry_in),
        .cfg_word (cfg_word),
        .cell_out (cell_out),
        .reg_out  (reg_out)
    );

    // Vector: {cfg[17:0], lut_in[3:0], carry_in, expected cell_out}, combinational mode
    localparam int NV = 10;
    localparam logic [23:0] VEC [NV] = '{
        {18'h08000, 4'hF, 1'b0, 1'b1},  // R8 all ones
        {18'h08000, 4'hE, 1'b0, 1'b0},  // R8 one zero
        {18'h08000, 4'h7, 1'b1, 1'b0},  // R8 top zero
        {18'h28000, 4'hE, 1'b1, 1'b1},  // R3 carry supplies I0
        {18'h28000, 4'hF, 1'b0, 1'b0},  // R3 lut_in[0] ignored
        {18'h00002, 4'h1, 1'b0, 1'b1},  // R2 routed I0
        {18'h00002, 4'h0, 1'b1, 1'b0},  // R2 carry ignored
        {18'h06996, 4'h7, 1'b0, 1'b1},  // R1 parity
        {18'h06996, 4'h3, 1'b0, 1'b0},  // R1 parity
        {18'h20001, 4'h1, 1'b0, 1'b1}   // R3 index 0 via carry 0
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ce = 1'b0; lut_in = '0; carry_in = 1'b0; cfg_word = '0;
        @(negedge clk);
        tick();
        check("R5 reset state", reg_out, 1'b0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            cfg_word = VEC[v][23:6];
            lut_in   = VEC[v][5:2];
            carry_in = VEC[v][1];
            #1;
            check("R1 vector table", cell_out, VEC[v][0]);
        end

        // R1: full sweep of tables, two input patterns each
        for (int t = 0; t < 65536; t++) begin
            logic [15:0] tt;
            logic [3:0]  ia;
            logic [3:0]  ib;
            tt = 16'(t);
            ia = 4'(t * 7 + 3);
            ib = tt[15:12] ^ tt[3:0];
            cfg_word = {2'b00, tt};
            carry_in = ~ia[0];
            lut_in   = ia;
            #1;
            check("R1 sweep a", cell_out, tt[ia]);
            lut_in = ib;
            #1;
            check("R1 sweep b", cell_out, tt[ib]);
        end
        @(negedge clk);

        // R6/R4: registered AND
        cfg_word = 18'h18000; lut_in = 4'hF; carry_in = 1'b0; ce = 1'b1;
        #1;
        check("R6 before edge", cell_out, 1'b0);
        tick();
        check("R4 capture", reg_out, 1'b1);
        check("R6 registered out", cell_out, 1'b1);
        ce = 1'b0; lut_in = 4'h0;
        tick();
        check("R4 hold", reg_out, 1'b1);
        check("R6 hold", cell_out, 1'b1);
        ce = 1'b1;
        tick();
        check("R4 capture zero", reg_out, 1'b0);

        // R7: reg_out visible in combinational mode
        lut_in = 4'hF;
        tick();
        cfg_word = 18'h08000; ce = 1'b0; lut_in = 4'h0;
        #1;
        check("R7 reg_out kept", reg_out, 1'b1);
        check("R1 comb differs", cell_out, 1'b0);

        // R3: registered with carry as I0
        cfg_word = 18'h38000; ce = 1'b1; lut_in = 4'hF; carry_in = 1'b0;
        tick();
        check("R3 registered carry 0", reg_out, 1'b0);
        lut_in = 4'hE; carry_in = 1'b1;
        tick();
        check("R3 registered carry 1", cell_out, 1'b1);

        // R5: reset beats enable
        rst = 1'b1; ce = 1'b1; lut_in = 4'hF;
        tick();
        check("R5 reset over ce", reg_out, 1'b0);
        check("R5 reset cell_out", cell_out, 1'b0);
        rst = 1'b0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule